// File: doc/BRIEF.md
# Transmit Descriptor Status and Early-Start Unit

This unit keeps the status words of four transmit descriptors and decides when the transmitter may begin sending the frame that the current descriptor describes. Software programs each descriptor with one full-width register write. That write carries a byte count, an early-start threshold code and an ownership flag. A descriptor is handed to the hardware by writing its ownership flag as 0.

The unit serves the descriptors strictly in ring order. It watches the transmit FIFO fill level and the "whole frame already in FIFO" flag, and pulses a start signal once the threshold condition holds. It then waits for the transmit result and records it into the descriptor status word. After that it moves on to the next descriptor. A separate DMA-done input hands ownership back to software by setting the ownership flag. Frames longer than the long-frame limit keep the ring from moving forward until their DMA has finished.

DMA, the MAC and collision handling are outside the block; their results arrive as plain inputs.

Top module: `tx_desc_unit`

## Requirements
- R1: After `rst`, every descriptor reads 0x0000_2000, with only the ownership flag (bit 13) set. `cur_idx` is 0 and `tx_start` is 0.
- R2: A write with `reg_wr_full`=1 to descriptor `reg_addr` stores byte count bits 12:0, threshold code bits 21:16 and ownership bit 13 from `reg_wdata`. All other bits then read 0. This clears any earlier result bits, and result-bit values written by software are discarded.
- R3: A write with `reg_wr_full`=0 leaves every descriptor unchanged.
- R4: The threshold code in bits 21:16 means 8 bytes when it is 0, and code×32 bytes otherwise. While idle, with the current descriptor's ownership flag at 0, `tx_start` is high for exactly one cycle. It rises in the cycle after the edge at which `fifo_count` is at or above the threshold.
- R5: `fifo_pkt_done`=1 satisfies the start condition whatever the fill level is.
- R6: Descriptors are served in the order 0, 1, 2, 3 and then 0 again. A descriptor whose ownership flag is 1 is never started. `cur_idx` shows the descriptor being served and advances when its result is recorded.
- R7: A result accepted while transmitting is written into the current descriptor. The layout is: bit 31 carrier lost, bit 30 abort, bit 29 late collision, bit 28 heartbeat fail, bits 27:24 collision count, bit 15 transmit OK, bit 14 underrun. Count, threshold and ownership bits are kept.
- R8: A result with underrun set stores bit 14 as 1 and bit 15 as 0, even when `res_ok` is 1.
- R9: When `link_100` is 1, the heartbeat-fail bit is stored as 0.
- R10: `dma_done` sets the ownership flag of descriptor `dma_idx`.
- R11: If a finished descriptor's byte count is above 1792, the next descriptor is not started until that descriptor's ownership flag is 1. A count of exactly 1792 does not hold the ring.
- R12: `soft_rst` clears every bit except the ownership flag in all descriptors and returns `cur_idx` to 0.
- R13: `tx_res_valid` while no transmission is in progress changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset pulse; the ownership flags are kept |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_full | input | 1 | 1 when the write is a full 32-bit access |
| reg_addr | input | 2 | Descriptor selected for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Status word of descriptor `reg_addr` |
| fifo_count | input | 12 | Bytes currently held in the transmit FIFO |
| fifo_pkt_done | input | 1 | FIFO holds at least one whole frame |
| dma_done | input | 1 | DMA finished for descriptor `dma_idx` |
| dma_idx | input | 2 | Descriptor whose DMA finished |
| tx_res_valid | input | 1 | Transmit result present this cycle |
| res_ok | input | 1 | Frame sent correctly |
| res_underrun | input | 1 | FIFO ran dry during the frame |
| res_carrier_lost | input | 1 | Carrier dropped during the frame |
| res_abort | input | 1 | Transmission aborted |
| res_late_coll | input | 1 | Collision outside the collision window |
| res_hb_fail | input | 1 | Heartbeat missing after the frame |
| res_coll_cnt | input | 4 | Collisions seen for the frame |
| link_100 | input | 1 | Link runs at 100 Mb/s |
| tx_start | output | 1 | One-cycle start request |
| cur_idx | output | 2 | Descriptor currently served |

## Verification
A wrong ring pointer shows at once on `cur_idx`, and shows as a start granted to a descriptor that software still owns. A wrong threshold decode shows on `tx_start` one cycle after the fill level crosses the boundary: starts come one step early, one step late or never. Errors in status recording, such as a lost underrun override, a heartbeat bit kept at 100 Mb/s or a stale result bit after a rewrite, appear on `reg_rdata` in the cycle after the result or write is accepted. A stuck long-frame hold shows as a missing start after DMA completes.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;

    localparam int SIZE_W = 13;
    localparam int THR_W  = 6;
    localparam int NCC_W  = 4;
    localparam int THR_CMP_W = 16;

    // Status word; field positions are software visible.
    typedef struct packed {
        logic             crs;      // 31 carrier lost
        logic             tabt;     // 30 abort
        logic             owc;      // 29 late collision
        logic             cdh;      // 28 heartbeat fail
        logic [NCC_W-1:0] ncc;      // 27:24 collisions
        logic [1:0]       rsv;      // 23:22
        logic [THR_W-1:0] thr;      // 21:16 early-start code
        logic             tok;      // 15
        logic             tun;      // 14
        logic             own;      // 13
        logic [SIZE_W-1:0] size;    // 12:0
    } tx_desc_t;

    typedef struct packed {
        logic             ok;
        logic             underrun;
        logic             carrier_lost;
        logic             abort;
        logic             late_coll;
        logic             hb_fail;
        logic [NCC_W-1:0] coll_cnt;
    } tx_result_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } tx_state_e;

    localparam tx_desc_t DESC_RESET = '{own: 1'b1, default: '0};

    function automatic logic [THR_CMP_W-1:0] thr_bytes(
        input logic [THR_W-1:0] code,
        input int unsigned      unit_b,
        input int unsigned      floor_b
    );
        if (code == '0)
            return THR_CMP_W'(floor_b);
        return THR_CMP_W'(code) * THR_CMP_W'(unit_b);
    endfunction

    function automatic tx_desc_t from_write(input logic [31:0] w);
        tx_desc_t wv;
        tx_desc_t n;
        wv     = tx_desc_t'(w);
        n      = '0;
        n.size = wv.size;
        n.thr  = wv.thr;
        n.own  = wv.own;
        return n;
    endfunction

    function automatic tx_desc_t with_result(
        input tx_desc_t   d,
        input tx_result_t r,
        input logic       fast
    );
        tx_desc_t n;
        n      = d;
        n.crs  = r.carrier_lost;
        n.tabt = r.abort;
        n.owc  = r.late_coll;
        n.cdh  = r.hb_fail & ~fast;
        n.ncc  = r.coll_cnt;
        n.tun  = r.underrun;
        n.tok  = r.ok & ~r.underrun;
        return n;
    endfunction

    function automatic tx_desc_t keep_owner(input tx_desc_t d);
        tx_desc_t n;
        n     = '0;
        n.own = d.own;
        return n;
    endfunction

endpackage

// File: rtl/tx_desc_store.sv
module tx_desc_store
    import tx_desc_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = $clog2(NUM_DESC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      soft_rst,
    input  logic                      wr_en,
    input  logic                      wr_full,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [31:0]               wdata,
    input  logic                      rec_en,
    input  logic [IDX_W-1:0]          rec_idx,
    input  tx_result_t                rec_res,
    input  logic                      fast,
    input  logic                      dma_done,
    input  logic [IDX_W-1:0]          dma_idx,
    output tx_desc_t [NUM_DESC-1:0]   desc_q
);

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
        tx_desc_t nxt_d;
        logic     hit_wr;
        logic     hit_rec;
        logic     hit_dma;

        assign hit_wr  = wr_en & wr_full & (wr_idx == IDX_W'(i));
        assign hit_rec = rec_en & (rec_idx == IDX_W'(i));
        assign hit_dma = dma_done & (dma_idx == IDX_W'(i));

        // Software write wins over hardware updates in the same cycle.
        always_comb begin
            nxt_d = desc_q[i];
            if (hit_rec)
                nxt_d = with_result(nxt_d, rec_res, fast);
            if (hit_dma)
                nxt_d.own = 1'b1;
            if (hit_wr)
                nxt_d = from_write(wdata);
        end

        always_ff @(posedge clk) begin
            if (rst)
                desc_q[i] <= DESC_RESET;
            else if (soft_rst)
                desc_q[i] <= keep_owner(desc_q[i]);
            else
                desc_q[i] <= nxt_d;
        end
    end

endmodule

// File: rtl/tx_thr_gate.sv
module tx_thr_gate
    import tx_desc_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int THR_UNIT = 32,
    parameter int THR_MIN  = 8
) (
    input  logic [THR_W-1:0] thr_code,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             pkt_done,
    output logic             ready
);

    localparam int CMP_W = (CNT_W > THR_CMP_W) ? CNT_W : THR_CMP_W;

    logic [CMP_W-1:0] need_b;
    logic [CMP_W-1:0] have_b;

    assign need_b = CMP_W'(thr_bytes(thr_code, THR_UNIT, THR_MIN));
    assign have_b = CMP_W'(fifo_count);
    assign ready  = pkt_done | (have_b >= need_b);

endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl
    import tx_desc_pkg::*;
#(
    parameter int NUM_DESC   = 4,
    parameter int IDX_W      = $clog2(NUM_DESC),
    parameter int LONG_LIMIT = 1792
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    soft_rst,
    input  tx_desc_t [NUM_DESC-1:0] desc_q,
    input  logic                    ready,
    input  logic                    res_valid,
    output logic [IDX_W-1:0]        cur_idx,
    output logic                    tx_start,
    output logic                    rec_en,
    output logic                    busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    tx_state_e        state_q;
    logic             long_wait_q;
    logic [IDX_W-1:0] long_idx_q;
    logic             long_block;
    logic             go;
    logic             cur_long;
    logic [IDX_W-1:0] next_idx;

    assign long_block = long_wait_q & ~desc_q[long_idx_q].own;
    assign go         = (state_q == ST_IDLE) & ~desc_q[cur_idx].own & ~long_block & ready;
    assign busy       = (state_q == ST_BUSY);
    assign rec_en     = busy & res_valid;
    assign cur_long   = (32'(desc_q[cur_idx].size) > 32'(LONG_LIMIT));
    assign next_idx   = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state_q     <= ST_IDLE;
            cur_idx     <= '0;
            tx_start    <= 1'b0;
            long_wait_q <= 1'b0;
            long_idx_q  <= '0;
        end else begin
            tx_start <= go;
            if (go)
                state_q <= ST_BUSY;
            if (rec_en) begin
                state_q     <= ST_IDLE;
                cur_idx     <= next_idx;
                long_wait_q <= cur_long;
                long_idx_q  <= cur_idx;
            end else if (long_wait_q && desc_q[long_idx_q].own) begin
                long_wait_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tx_desc_unit.sv
module tx_desc_unit
    import tx_desc_pkg::*;
#(
    parameter int NUM_DESC   = 4,
    parameter int CNT_W      = 12,
    parameter int THR_UNIT   = 32,
    parameter int THR_MIN    = 8,
    parameter int LONG_LIMIT = 1792,
    localparam int IDX_W     = $clog2(NUM_DESC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  reg_wr_en,
    input  logic                  reg_wr_full,
    input  logic [IDX_W-1:0]      reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [CNT_W-1:0]      fifo_count,
    input  logic                  fifo_pkt_done,
    input  logic                  dma_done,
    input  logic [IDX_W-1:0]      dma_idx,
    input  logic                  tx_res_valid,
    input  logic                  res_ok,
    input  logic                  res_underrun,
    input  logic                  res_carrier_lost,
    input  logic                  res_abort,
    input  logic                  res_late_coll,
    input  logic                  res_hb_fail,
    input  logic [NCC_W-1:0]      res_coll_cnt,
    input  logic                  link_100,
    output logic                  tx_start,
    output logic [IDX_W-1:0]      cur_idx
);

    tx_desc_t [NUM_DESC-1:0] desc_all;
    tx_result_t              res_bus;
    logic                    rec_en;
    logic                    busy;
    logic                    ready;

    assign res_bus = '{ok:           res_ok,
                       underrun:     res_underrun,
                       carrier_lost: res_carrier_lost,
                       abort:        res_abort,
                       late_coll:    res_late_coll,
                       hb_fail:      res_hb_fail,
                       coll_cnt:     res_coll_cnt};

    tx_desc_store #(
        .NUM_DESC (NUM_DESC),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (reg_wr_en),
        .wr_full  (reg_wr_full),
        .wr_idx   (reg_addr),
        .wdata    (reg_wdata),
        .rec_en   (rec_en),
        .rec_idx  (cur_idx),
        .rec_res  (res_bus),
        .fast     (link_100),
        .dma_done (dma_done),
        .dma_idx  (dma_idx),
        .desc_q   (desc_all)
    );

    tx_thr_gate #(
        .CNT_W    (CNT_W),
        .THR_UNIT (THR_UNIT),
        .THR_MIN  (THR_MIN)
    ) u_gate (
        .thr_code   (desc_all[cur_idx].thr),
        .fifo_count (fifo_count),
        .pkt_done   (fifo_pkt_done),
        .ready      (ready)
    );

    tx_start_ctrl #(
        .NUM_DESC   (NUM_DESC),
        .IDX_W      (IDX_W),
        .LONG_LIMIT (LONG_LIMIT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .desc_q    (desc_all),
        .ready     (ready),
        .res_valid (tx_res_valid),
        .cur_idx   (cur_idx),
        .tx_start  (tx_start),
        .rec_en    (rec_en),
        .busy      (busy)
    );

    assign reg_rdata = desc_all[reg_addr];

endmodule

// File: rtl/tx_desc_checker.sv
module tx_desc_checker
    import tx_desc_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int IDX_W    = $clog2(NUM_DESC)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    soft_rst,
    input logic                    reg_wr_en,
    input logic                    reg_wr_full,
    input logic [IDX_W-1:0]        reg_addr,
    input logic                    dma_done,
    input logic [IDX_W-1:0]        dma_idx,
    input logic                    tx_res_valid,
    input logic                    link_100,
    input logic                    tx_start,
    input logic [IDX_W-1:0]        cur_idx,
    input logic                    busy,
    input logic                    rec_en,
    input tx_desc_t [NUM_DESC-1:0] desc_all
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    // R4: a start request lasts one cycle
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    // R6: the ring pointer only steps forward by one, with wrap
    p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(soft_rst) && cur_idx != $past(cur_idx)) |->
        cur_idx == (($past(cur_idx) == LAST_IDX) ? '0 : $past(cur_idx) + 1'b1));

    // R12: software reset returns the pointer and quiets start
    p_soft_rst_r12: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cur_idx == '0 && !tx_start));

    // R3: narrow writes alone leave the descriptors untouched
    p_narrow_write_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !reg_wr_full && !dma_done && !tx_res_valid && !soft_rst)
        |=> $stable(desc_all));

    // R13: results outside a transmission change nothing
    p_idle_result_r13: assert property (@(posedge clk) disable iff (rst)
        (tx_res_valid && !busy && !dma_done && !reg_wr_en && !soft_rst)
        |=> $stable(desc_all));

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_chk
        // R8: underrun and transmit OK never read together
        p_underrun_no_ok_r8: assert property (@(posedge clk) disable iff (rst)
            desc_all[i].tun |-> !desc_all[i].tok);

        // R10: completed DMA hands the descriptor back
        p_dma_own_r10: assert property (@(posedge clk) disable iff (rst)
            (dma_done && dma_idx == IDX_W'(i) && !soft_rst &&
             !(reg_wr_en && reg_wr_full && reg_addr == IDX_W'(i)))
            |=> desc_all[i].own);

        // R9: no heartbeat failure recorded at 100 Mb/s
        p_hb_fast_r9: assert property (@(posedge clk) disable iff (rst)
            (rec_en && cur_idx == IDX_W'(i) && link_100 && !soft_rst &&
             !(reg_wr_en && reg_wr_full && reg_addr == IDX_W'(i)))
            |=> !desc_all[i].cdh);
    end

endmodule

bind tx_desc_unit tx_desc_checker #(
    .NUM_DESC (NUM_DESC),
    .IDX_W    (IDX_W)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_full  (reg_wr_full),
    .reg_addr     (reg_addr),
    .dma_done     (dma_done),
    .dma_idx      (dma_idx),
    .tx_res_valid (tx_res_valid),
    .link_100     (link_100),
    .tx_start     (tx_start),
    .cur_idx      (cur_idx),
    .busy         (busy),
    .rec_en       (rec_en),
    .desc_all     (desc_all)
);

// File: tb/tx_desc_unit_bench.sv
module tx_desc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_full = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] fifo_count = '0;
    logic        fifo_pkt_done = 1'b0;
    logic        dma_done = 1'b0;
    logic [1:0]  dma_idx = '0;
    logic        tx_res_valid = 1'b0;
    logic        res_ok = 1'b0;
    logic        res_underrun = 1'b0;
    logic        res_carrier_lost = 1'b0;
    logic        res_abort = 1'b0;
    logic        res_late_coll = 1'b0;
    logic        res_hb_fail = 1'b0;
    logic [3:0]  res_coll_cnt = '0;
    logic        link_100 = 1'b0;
    logic        tx_start;
    logic [1:0]  cur_idx;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    tx_desc_unit u_tx_desc_unit (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [1:0] idx, input logic [31:0] exp);
        reg_addr = idx;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] data, input logic full);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_full = full; reg_addr = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_full = 1'b0;
    endtask

    task automatic give_result(input logic ok, input logic un, input logic crs,
                               input logic ab, input logic owc, input logic hb,
                               input logic [3:0] ncc, input logic fast);
        @(negedge clk);
        tx_res_valid = 1'b1; res_ok = ok; res_underrun = un; res_carrier_lost = crs;
        res_abort = ab; res_late_coll = owc; res_hb_fail = hb; res_coll_cnt = ncc;
        link_100 = fast;
        @(negedge clk);
        tx_res_valid = 1'b0;
    endtask

    function automatic int exp_thr(input logic [5:0] code);
        return (code == 0) ? 8 : int'(code) * 32;
    endfunction

    function automatic logic [31:0] exp_word(input logic [12:0] size, input logic [5:0] thr,
            input logic own, input logic ok, input logic un, input logic crs, input logic ab,
            input logic owc, input logic hb, input logic [3:0] ncc, input logic fast);
        logic [31:0] w;
        w = {19'd0, size};
        w[21:16] = thr;
        w[13] = own;
        w[31] = crs; w[30] = ab; w[29] = owc; w[28] = hb & ~fast;
        w[27:24] = ncc;
        w[14] = un;
        w[15] = ok & ~un;
        return w;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [1:0] exp_cur;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 4; i++) read_chk("R1 reset word", 2'(i), 32'h0000_2000);
        chk("R1 cur_idx", 32'(cur_idx), 0);
        chk("R1 tx_start", 32'(tx_start), 0);

        // R2 full write discards result bits
        wr(2'd0, 32'hFFFF_FFFF, 1'b1);
        read_chk("R2 full write", 2'd0, 32'h003F_3FFF);
        // R3 narrow write ignored
        wr(2'd0, 32'h0000_0000, 1'b0);
        read_chk("R3 narrow write", 2'd0, 32'h003F_3FFF);

        // R6 owned descriptor never starts even with a full frame
        fifo_pkt_done = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R6 owned not started", 32'(tx_start), 0);
        // R5 frame-complete flag starts despite a 2016-byte threshold
        wr(2'd0, 32'h003F_003C, 1'b1);
        @(negedge clk);
        chk("R5 start on complete frame", 32'(tx_start), 1);
        fifo_pkt_done = 1'b0;
        @(negedge clk);
        chk("R4 start is one cycle", 32'(tx_start), 0);
        // R7 R8 result recorded; underrun wins over OK
        give_result(1, 1, 1, 0, 0, 1, 4'd5, 0);
        read_chk("R7 R8 result word", 2'd0, 32'h953F_403C);
        chk("R6 advance to 1", 32'(cur_idx), 1);

        // R4 code 0 means 8 bytes
        wr(2'd1, 32'h0000_0064, 1'b1);
        fifo_count = 12'd7;
        @(negedge clk); @(negedge clk);
        chk("R4 below 8 bytes", 32'(tx_start), 0);
        fifo_count = 12'd8;
        @(negedge clk);
        chk("R4 at 8 bytes", 32'(tx_start), 1);
        fifo_count = 12'd0;
        // R9 heartbeat fail dropped at 100 Mb/s
        give_result(1, 0, 0, 0, 0, 1, 4'd0, 1);
        read_chk("R9 heartbeat at 100M", 2'd1, 32'h0000_8064);

        // R13 result while idle ignored
        give_result(0, 0, 0, 1, 1, 0, 4'd3, 0);
        read_chk("R13 idle result desc1", 2'd1, 32'h0000_8064);
        read_chk("R13 idle result desc2", 2'd2, 32'h0000_2000);
        chk("R13 cur unchanged", 32'(cur_idx), 2);

        // R2 rewrite clears recorded result
        wr(2'd1, 32'h0000_2064, 1'b1);
        read_chk("R2 rewrite clears", 2'd1, 32'h0000_2064);

        // R10 DMA done sets ownership
        @(negedge clk); dma_done = 1'b1; dma_idx = 2'd0;
        @(negedge clk); dma_done = 1'b0;
        read_chk("R10 dma sets own", 2'd0, 32'h953F_603C);

        // R11 long frame holds the ring
        wr(2'd2, 32'h0000_0701, 1'b1);
        fifo_count = 12'd8;
        @(negedge clk);
        chk("R11 long frame starts", 32'(tx_start), 1);
        give_result(1, 0, 0, 0, 0, 0, 4'd0, 0);
        chk("R6 advance to 3", 32'(cur_idx), 3);
        fifo_count = 12'd0;
        wr(2'd3, 32'h0000_0700, 1'b1);
        fifo_count = 12'd8;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R11 held until owner set", 32'(tx_start), 0);
        dma_done = 1'b1; dma_idx = 2'd2;
        @(negedge clk); dma_done = 1'b0;
        chk("R11 still held at dma edge", 32'(tx_start), 0);
        @(negedge clk);
        chk("R11 released after dma", 32'(tx_start), 1);
        give_result(1, 0, 0, 0, 0, 0, 4'd0, 0);
        chk("R6 wrap to 0", 32'(cur_idx), 0);
        // R11 exactly 1792 does not hold
        wr(2'd0, 32'h0000_0005, 1'b1);
        @(negedge clk);
        chk("R11 1792 not held", 32'(tx_start), 1);
        fifo_count = 12'd0;
        give_result(1, 0, 0, 0, 0, 0, 4'd0, 0);
        read_chk("R7 ok word", 2'd0, 32'h0000_8005);

        // R12 soft reset keeps only ownership
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        read_chk("R12 desc0", 2'd0, 32'h0000_0000);
        read_chk("R12 desc2", 2'd2, 32'h0000_2000);
        chk("R12 cur to 0", 32'(cur_idx), 0);

        // R4 R6 R7 random thresholds and results
        exp_cur = 2'd0;
        for (int it = 0; it < 40; it++) begin
            logic [5:0]  code;
            logic [12:0] size;
            logic [11:0] cnt;
            logic [3:0]  ncc;
            logic        ok, un, crs, ab, owc, hb, fast;
            code = 6'($urandom_range(0, 63));
            size = 13'($urandom_range(1, 1500));
            cnt  = 12'($urandom_range(0, 2100));
            {ok, un, crs, ab, owc, hb, fast} = 7'($urandom);
            ncc  = 4'($urandom);
            fifo_count = 12'd0;
            wr(exp_cur, {10'd0, code, 3'b000, size}, 1'b1);
            fifo_count = cnt;
            @(negedge clk);
            chk("R4 random threshold", 32'(tx_start), 32'(int'(cnt) >= exp_thr(code)));
            if (!tx_start) begin
                fifo_count = 12'(exp_thr(code));
                @(negedge clk);
                chk("R4 random at threshold", 32'(tx_start), 1);
            end
            fifo_count = 12'd0;
            give_result(ok, un, crs, ab, owc, hb, ncc, fast);
            read_chk("R7 random result", exp_cur,
                     exp_word(size, code, 1'b0, ok, un, crs, ab, owc, hb, ncc, fast));
            exp_cur = exp_cur + 2'd1;
            chk("R6 random order", 32'(cur_idx), 32'(exp_cur));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule